// File: doc/BRIEF.md
# Message-Signalled Interrupt Frame Receiver

This block listens to a memory-mapped write bus and turns posted doorbell writes from peripherals into interrupt pulses for a parent interrupt controller. The address space holds a number of identical frames, each with its own 16 KiB window laid out back to back from a common base address. A peripheral raises an event by writing that event's number into the upper data field of the doorbell register, which sits at one fixed offset inside its frame's window.

Every frame owns eight events and a block of eight consecutive output lines that starts at a per-frame base line. When the block accepts a write that decodes correctly, it drives a one-cycle rising-edge pulse on exactly one line of a flat output vector. A write it cannot map produces no pulse. Such a write instead sets a sticky error flag, which stays set until a separate clear input resets it. The base address and the per-frame base lines are fixed at elaboration.

Top module: `msi_frame_rx`

## Requirements
- R1: Frame f (0..3) owns byte addresses BASE_ADDR + f*0x4000 up to BASE_ADDR + f*0x4000 + 0x3FFF, with BASE_ADDR defaulting to 0x0030_0000. A write below BASE_ADDR, or at or above BASE_ADDR + 0x10000, produces no pulse.
- R2: Only a write whose byte offset inside its frame window is exactly 0x40 can trigger an event. Any other offset produces no pulse.
- R3: The event number is the value of data bits [31:12]. Data bits [11:0] have no effect on the result.
- R4: A write whose event number is 8 or more produces no pulse.
- R5: Event n of frame f drives output line LINE_BASE[f] + n. The default bases are 128, 136, 144 and 152 for frames 0 to 3.
- R6: A write that is accepted and decodes correctly drives exactly one output line high for exactly one cycle, in the cycle after acceptance. Writes on back-to-back cycles give pulses on back-to-back cycles.
- R7: wr_ready is always high, so one write is accepted in every cycle in which wr_valid is high.
- R8: An accepted write that breaks R1, R2 or R4 sets err_flag in the next cycle. err_flag then stays high until it is cleared.
- R9: err_clr high clears err_flag in the next cycle. If a rejected write is accepted in the same cycle as err_clr, the set wins and err_flag stays high.
- R10: While rst is high, irq_out is all zero and err_flag is low from the next clock edge on.
- R11: While wr_valid is low, the address and data buses have no effect: no pulse appears and err_flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 32 | Byte address of the write |
| wr_data | input | 32 | Write data; event number in bits [31:12] |
| err_clr | input | 1 | Clears the sticky error flag |
| irq_out | output | 160 | One-cycle interrupt pulses toward the parent controller |
| err_flag | output | 1 | Sticky flag for rejected writes |

## Verification
Two things can land in the same cycle on the error flag: a rejected write that sets it and an err_clr that clears it. The bench drives a bad doorbell and err_clr together and expects the flag to stay set. It also drives err_clr alongside a valid doorbell and expects the flag to drop while the pulse still appears. On every clock the behavioural model's predicted flag and line vector are compared with the design's, so the priority between set and clear is judged cycle by cycle, not only at the end.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  // Reason a write did not produce an event.
  typedef enum logic [1:0] {
    REJ_NONE   = 2'd0,
    REJ_WINDOW = 2'd1,
    REJ_OFFSET = 2'd2,
    REJ_EVENT  = 2'd3
  } rej_e;

  localparam int LINE_IDX_W = 16;

  function automatic rej_e classify(input logic in_win, input logic at_set, input logic ev_ok);
    if (!in_win)      return REJ_WINDOW;
    else if (!at_set) return REJ_OFFSET;
    else if (!ev_ok)  return REJ_EVENT;
    else              return REJ_NONE;
  endfunction
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0030_0000,
  parameter int                NUM_FRAMES = 4,
  parameter int                WIN_SHIFT  = 14,
  parameter int                SET_OFFSET = 'h40,
  localparam int               FRAME_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               in_win,
  output logic               at_set,
  output logic [FRAME_W-1:0] frame_idx
);
  localparam logic [ADDR_W-1:0]    NF_A   = ADDR_W'(NUM_FRAMES);
  localparam logic [WIN_SHIFT-1:0] OFS_W  = WIN_SHIFT'(SET_OFFSET);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel       = addr - BASE_ADDR;
    in_win    = (addr >= BASE_ADDR) && ((rel >> WIN_SHIFT) < NF_A);
    at_set    = (rel[WIN_SHIFT-1:0] == OFS_W);
    frame_idx = rel[WIN_SHIFT +: FRAME_W];
  end
endmodule

// File: rtl/msi_event_extract.sv
module msi_event_extract #(
  parameter int  FIELD_W  = 20,
  parameter int  EV_SHIFT = 3
) (
  input  logic [FIELD_W-1:0]  field,
  output logic                ev_ok,
  output logic [EV_SHIFT-1:0] ev_num
);
  always_comb begin
    ev_ok  = ((field >> EV_SHIFT) == '0);
    ev_num = field[EV_SHIFT-1:0];
  end
endmodule

// File: rtl/msi_line_map.sv
module msi_line_map #(
  parameter int                          NUM_FRAMES = 4,
  parameter int                          EV_SHIFT   = 3,
  parameter int                          OUT_W      = 160,
  parameter logic [NUM_FRAMES*16-1:0]    LINE_BASE  = {16'd152, 16'd144, 16'd136, 16'd128},
  localparam int                         FRAME_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int                         EVENTS     = 1 << EV_SHIFT
) (
  input  logic                fire,
  input  logic [FRAME_W-1:0]  frame_idx,
  input  logic [EV_SHIFT-1:0] ev_num,
  output logic [OUT_W-1:0]    line_vec
);
  logic [EVENTS-1:0] ev_dec;
  logic [OUT_W-1:0]  part [NUM_FRAMES];

  always_comb begin
    ev_dec = '0;
    ev_dec[ev_num] = 1'b1;
  end

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    localparam int FBASE = int'(LINE_BASE[f*16 +: 16]);
    logic sel;
    assign sel     = fire && (frame_idx == FRAME_W'(f));
    assign part[f] = sel ? (OUT_W'(ev_dec) << FBASE) : '0;
  end

  always_comb begin
    line_vec = '0;
    for (int f = 0; f < NUM_FRAMES; f++) line_vec = line_vec | part[f];
  end
endmodule

// File: rtl/msi_frame_rx.sv
module msi_frame_rx #(
  parameter int                       ADDR_W     = 32,
  parameter int                       DATA_W     = 32,
  parameter logic [ADDR_W-1:0]        BASE_ADDR  = 32'h0030_0000,
  parameter int                       NUM_FRAMES = 4,
  parameter int                       WIN_SHIFT  = 14,
  parameter int                       SET_OFFSET = 'h40,
  parameter int                       EV_LSB     = 12,
  parameter int                       EV_SHIFT   = 3,
  parameter int                       OUT_W      = 160,
  parameter logic [NUM_FRAMES*16-1:0] LINE_BASE  = {16'd152, 16'd144, 16'd136, 16'd128}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  output logic [OUT_W-1:0]  irq_out,
  output logic              err_flag
);
  import msi_rx_pkg::*;

  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int FIELD_W = DATA_W - EV_LSB;

  logic                in_win, at_set, ev_ok, fire, reject;
  logic [FRAME_W-1:0]  frame_idx;
  logic [EV_SHIFT-1:0] ev_num;
  logic [OUT_W-1:0]    line_vec;
  logic [OUT_W-1:0]    irq_q;
  logic                err_q;
  rej_e                why;
  logic                unused_low;

  assign unused_low = ^wr_data[EV_LSB-1:0];
  assign wr_ready   = 1'b1;

  msi_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_FRAMES(NUM_FRAMES),
    .WIN_SHIFT(WIN_SHIFT), .SET_OFFSET(SET_OFFSET)
  ) u_dec (
    .addr(wr_addr), .in_win(in_win), .at_set(at_set), .frame_idx(frame_idx)
  );

  msi_event_extract #(.FIELD_W(FIELD_W), .EV_SHIFT(EV_SHIFT)) u_ev (
    .field(wr_data[DATA_W-1:EV_LSB]), .ev_ok(ev_ok), .ev_num(ev_num)
  );

  always_comb begin
    why    = classify(in_win, at_set, ev_ok);
    fire   = wr_valid && (why == REJ_NONE);
    reject = wr_valid && (why != REJ_NONE);
  end

  msi_line_map #(
    .NUM_FRAMES(NUM_FRAMES), .EV_SHIFT(EV_SHIFT), .OUT_W(OUT_W), .LINE_BASE(LINE_BASE)
  ) u_map (
    .fire(fire), .frame_idx(frame_idx), .ev_num(ev_num), .line_vec(line_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      err_q <= 1'b0;
    end else begin
      irq_q <= line_vec;
      if (reject)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign irq_out  = irq_q;
  assign err_flag = err_q;
endmodule

// File: rtl/msi_frame_rx_chk.sv
module msi_frame_rx_chk #(
  parameter int OUT_W = 160
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             err_clr,
  input logic [OUT_W-1:0] irq_out,
  input logic             err_flag
);
  p_ready_r7: assert property (@(posedge clk) disable iff (rst) wr_ready);

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_out));

  p_pulse_src_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(wr_valid));

  p_err_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(wr_valid));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  p_err_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !wr_valid) |=> !err_flag);

  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> !$rose(err_flag));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> ((irq_out == '0) && !err_flag));
endmodule

bind msi_frame_rx msi_frame_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .err_clr(err_clr), .irq_out(irq_out), .err_flag(err_flag)
);

// File: tb/msi_frame_rx_test.sv
module msi_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT       = 160;
  localparam longint BASE   = 64'h30_0000;
  localparam longint WIN    = 64'h4000;

  logic            clk = 1'b0;
  logic            rst, wr_valid, err_clr;
  logic            wr_ready, err_flag;
  logic [31:0]     wr_addr, wr_data;
  logic [NOUT-1:0] irq_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [NOUT-1:0] exp_irq = '0;
  logic            exp_err = 1'b0;
  int              bases [4] = '{128, 136, 144, 152};

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_frame_rx uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .err_clr(err_clr),
    .irq_out(irq_out), .err_flag(err_flag)
  );

  // Behavioural prediction of the outputs after the next clock edge.
  task automatic predict(input bit r, input bit v, input longint a, input longint d, input bit c);
    longint rel, ev;
    exp_irq = '0;
    if (r) begin
      exp_err = 1'b0;
    end else if (v) begin
      rel = a - BASE;
      ev  = d >> 12;
      if (a >= BASE && rel < 4 * WIN && (rel % WIN) == 64'h40 && ev < 8)
        exp_irq[bases[int'(rel / WIN)] + int'(ev)] = 1'b1;
      else
        exp_err = 1'b1;
      if (exp_irq != '0 && c) exp_err = 1'b0;
    end else if (c) begin
      exp_err = 1'b0;
    end
  endtask

  task automatic step(input bit r, input bit v, input longint a, input longint d,
                      input bit c, input string tag);
    rst = r; wr_valid = v; wr_addr = a[31:0]; wr_data = d[31:0]; err_clr = c;
    predict(r, v, a, d, c);
    @(negedge clk);
    checks++;
    if (irq_out !== exp_irq) begin
      errors++;
      $display("FAIL %s irq_out actual=%h expected=%h", tag, irq_out, exp_irq);
    end
    checks++;
    if (err_flag !== exp_err) begin
      errors++;
      $display("FAIL %s err_flag actual=%b expected=%b", tag, err_flag, exp_err);
    end
    if (!r) begin
      checks++;
      if (wr_ready !== 1'b1) begin
        errors++;
        $display("FAIL R7 wr_ready actual=%b expected=1", wr_ready);
      end
    end
  endtask

  function automatic longint door(input int f);
    return BASE + longint'(f) * WIN + 64'h40;
  endfunction

  initial begin
    step(1, 0, 0, 0, 0, "R10");
    step(1, 1, door(0), 0, 0, "R10");
    // every event of every frame, back to back
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 8; e++)
        step(0, 1, door(f), longint'(e) << 12, 0, "R5");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 1, door(2), (64'd5 << 12) | 64'hABC, 0, "R3");
    step(0, 1, door(1), (64'd0 << 12) | 64'hFFF, 0, "R3");
    step(0, 0, door(1), 64'd3 << 12, 0, "R11");
    // window misses
    step(0, 1, BASE - WIN + 64'h40, 64'd1 << 12, 0, "R1");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, "R9");
    step(0, 1, BASE + 4 * WIN + 64'h40, 64'd1 << 12, 0, "R1");
    step(0, 1, door(3) - 64'h40 + 64'h3FFF, 64'd1 << 12, 1, "R9");
    step(0, 0, 0, 0, 1, "R9");
    // offset misses
    step(0, 1, door(0) + 4, 64'd2 << 12, 0, "R2");
    step(0, 0, 0, 0, 1, "R9");
    step(0, 1, door(1) - 4, 64'd2 << 12, 0, "R2");
    step(0, 1, BASE, 64'd2 << 12, 0, "R2");
    // good write together with a clear
    step(0, 1, door(3), 64'd7 << 12, 1, "R9");
    // event number out of range
    step(0, 1, door(2), 64'd8 << 12, 0, "R4");
    step(0, 0, 0, 0, 1, "R9");
    step(0, 1, door(0), 64'hFFFFF << 12, 0, "R4");
    step(0, 0, door(0), 64'd1 << 12, 1, "R11");
    step(0, 1, door(3), 64'd0, 0, "R6");
    step(0, 1, door(3), 64'd0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // reset mid-run after an error
    step(0, 1, BASE + 64'h44, 0, 0, "R8");
    step(1, 1, door(1), 64'd1 << 12, 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule